// File: doc/BRIEF.md
# Extensible Multiply Divide Unit

This block carries out the double-length unsigned integer multiply and divide operations of a processor whose integer file holds eight 64-bit registers. Three operand sizes are supported: halfword (16-bit operands), integer (32-bit operands) and long (64-bit operands). A multiply yields a product twice as wide as its operands. A divide takes a dividend twice as wide as the divisor and returns a remainder and a quotient, each also twice the divisor width. Because the quotient is double-length, it can never overflow.

The surrounding pipeline raises `start` for one cycle with the operation, size, destination register number and the operand values read from the file: the destination register, the register after it, and the source register. The unit checks the register-number alignment rules and the divisor. It then returns results through a two-lane register write port that carries one or two writes per cycle, and pulses `done` in its final cycle. A multiply finishes in the cycle after acceptance. A divide runs a restoring divider with one cycle per dividend bit.

Control is a single state machine with these states:
- `ST_IDLE`: waiting for a request.
- `ST_MUL_WB`: writing the product.
- `ST_DIV_RUN`: stepping the divider.
- `ST_DIV_WB_A`: writing the remainder, and for the halfword and integer sizes also the quotient.
- `ST_DIV_WB_B`: writing the long quotient.
- `ST_FAULT`: reporting a rejected request.

Transitions:
- `ST_IDLE` to `ST_FAULT` on an accepted request that breaks a rule.
- `ST_IDLE` to `ST_MUL_WB` on an accepted multiply.
- `ST_IDLE` to `ST_DIV_RUN` on an accepted divide.
- `ST_DIV_RUN` stays in place until the step count is used up, then goes to `ST_DIV_WB_A`.
- `ST_DIV_WB_A` goes to `ST_DIV_WB_B` for the long size, and to `ST_IDLE` otherwise.
- `ST_MUL_WB`, `ST_DIV_WB_B` and `ST_FAULT` each return to `ST_IDLE`.

Top module: `emd_unit`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `err_align`, `err_zero`, `wr0_en` and `wr1_en` are all low.
- R2: A request is taken only when `start` is high in a cycle where `busy` is low. `start` is ignored while `busy` is high, whatever the other inputs carry, and the running operation's results are unchanged.
- R3: Multiply uses `op_div`=0. For `size`=00 (halfword) or 01 (integer), the cycle after acceptance has `busy`=1 and `done`=1, and lane 0 writes register `dst_idx`. The data is the product of the low 16 (or low 32) bits of `dst_val` and `src_val`, zero-extended to 64 bits. Lane 1 is idle and the upper operand bits have no effect.
- R4: Multiply with `size`=10 (long) needs an odd `dst_idx`. The cycle after acceptance has `done`=1. Lane 0 writes the upper 64 bits of the 128-bit product of `dst_val` and `src_val` to register `dst_idx`-1. Lane 1 writes the lower 64 bits to `dst_idx`.
- R5: Divide uses `op_div`=1. For `size`=00, `dst_idx` must be even, the dividend is the low 32 bits of `dst_val` and the divisor is the low 16 bits of `src_val`. After 32 busy cycles without writes, a single `done` cycle follows. In it, lane 0 writes the remainder to `dst_idx` and lane 1 writes the quotient to `dst_idx`+1, both zero-extended.
- R6: Divide with `size`=01 needs an even `dst_idx`. The dividend is all 64 bits of `dst_val` and the divisor is the low 32 bits of `src_val`. The writes follow the pattern of R5 after 64 busy cycles.
- R7: Divide with `size`=10 needs `dst_idx` to be a multiple of four. The dividend is the 128-bit value {`dst_val`, `dst_next_val`} and the divisor is `src_val`. After 128 busy cycles, a cycle with `done`=0 writes the remainder: upper half to `dst_idx` on lane 0, lower half to `dst_idx`+1 on lane 1. The next cycle has `done`=1 and writes the quotient: upper half to `dst_idx`+2 on lane 0, lower half to `dst_idx`+3 on lane 1.
- R8: The quotient is always returned in full at twice the divisor width. An all-ones dividend divided by 1 yields an all-ones quotient, with no error.
- R9: A broken rule gives one cycle with `done`=1 and `err_align`=1, and no write on either lane. The rules are: a reserved `size`=11, an even destination for the long multiply, an odd destination for the halfword or integer divide, and a destination that is not a multiple of four for the long divide.
- R10: A divide whose size-selected divisor is zero, while the alignment rules hold, gives one cycle with `done`=1 and `err_zero`=1, and no write. An alignment error takes precedence, so the two flags are never high together.
- R11: `busy` stays high from the cycle after acceptance through the cycle where `done` is high. `done` lasts one cycle and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken when idle |
| op_div | input | 1 | 0 multiply, 1 divide |
| size | input | 2 | 00 halfword, 01 integer, 10 long, 11 reserved |
| dst_idx | input | 3 | Destination register number |
| dst_val | input | 64 | Contents of the destination register |
| dst_next_val | input | 64 | Contents of the register after the destination (long divide) |
| src_val | input | 64 | Contents of the source register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of an operation |
| err_align | output | 1 | Register-number rule broken (with done) |
| err_zero | output | 1 | Divisor zero (with done) |
| wr0_en | output | 1 | Write lane 0 enable |
| wr0_idx | output | 3 | Write lane 0 register number |
| wr0_data | output | 64 | Write lane 0 data |
| wr1_en | output | 1 | Write lane 1 enable |
| wr1_idx | output | 3 | Write lane 1 register number |
| wr1_data | output | 64 | Write lane 1 data |

## Verification
The bench builds the unit with its default parameters: a 64-bit register width and eight registers. This exercises the full 128-bit dividend path, the longest 128-step divide, and both ends of the register numbering, including a long multiply into register 7 and a long divide at register 4 whose quotient lands in registers 6 and 7. With these widths the bench's own 128-bit arithmetic provides exact expected products, quotients and remainders. The all-ones dividend over 1 shows the quotient never overflows.

// File: rtl/emd_pkg.sv
package emd_pkg;

    typedef enum logic [1:0] {
        SZ_HALF = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } emd_size_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_MUL_WB   = 3'd1,
        ST_DIV_RUN  = 3'd2,
        ST_DIV_WB_A = 3'd3,
        ST_DIV_WB_B = 3'd4,
        ST_FAULT    = 3'd5
    } emd_state_e;

endpackage

// File: rtl/emd_opcheck.sv
module emd_opcheck
    import emd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            op_div,
    input  logic [1:0]      size,
    input  logic [1:0]      dst_lo,
    input  logic [XLEN-1:0] src_val,
    output logic            align_bad,
    output logic            zero_bad,
    output logic [XLEN-1:0] divisor
);
    localparam int HW = XLEN / 4;
    localparam int WW = XLEN / 2;

    emd_size_e sz;
    assign sz = emd_size_e'(size);

    // divisor selected by operand size
    always_comb begin
        unique case (sz)
            SZ_HALF: divisor = {{(XLEN-HW){1'b0}}, src_val[HW-1:0]};
            SZ_WORD: divisor = {{(XLEN-WW){1'b0}}, src_val[WW-1:0]};
            default: divisor = src_val;
        endcase
    end

    // register-number rules
    always_comb begin
        if (sz == SZ_RSVD) begin
            align_bad = 1'b1;
        end else if (!op_div) begin
            align_bad = (sz == SZ_LONG) && !dst_lo[0];
        end else if (sz == SZ_LONG) begin
            align_bad = (dst_lo != 2'b00);
        end else begin
            align_bad = dst_lo[0];
        end
        zero_bad = op_div && !align_bad && (divisor == '0);
    end

endmodule

// File: rtl/emd_mul.sv
module emd_mul
    import emd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0]        size,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [2*XLEN-1:0] prod
);
    localparam int DW = 2 * XLEN;
    localparam int HW = XLEN / 4;
    localparam int WW = XLEN / 2;

    logic [XLEN-1:0] am, bm;

    always_comb begin
        unique case (emd_size_e'(size))
            SZ_HALF: begin
                am = {{(XLEN-HW){1'b0}}, a[HW-1:0]};
                bm = {{(XLEN-HW){1'b0}}, b[HW-1:0]};
            end
            SZ_WORD: begin
                am = {{(XLEN-WW){1'b0}}, a[WW-1:0]};
                bm = {{(XLEN-WW){1'b0}}, b[WW-1:0]};
            end
            default: begin
                am = a;
                bm = b;
            end
        endcase
        prod = DW'(am) * DW'(bm);
    end

endmodule

// File: rtl/emd_div.sv
module emd_div #(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [2*XLEN-1:0] dividend_in,
    input  logic [XLEN-1:0]   divisor_in,
    output logic [2*XLEN-1:0] quot,
    output logic [XLEN-1:0]   rem
);
    localparam int DW = 2 * XLEN;

    logic [DW-1:0]   q_r;
    logic [XLEN-1:0] r_r;
    logic [XLEN-1:0] d_r;
    logic [XLEN:0]   trial;
    logic [XLEN:0]   diff;
    logic            fits;

    // one restoring step: shift in next dividend bit, try subtract
    always_comb begin
        trial = {r_r, q_r[DW-1]};
        diff  = trial - {1'b0, d_r};
        fits  = !diff[XLEN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
            r_r <= '0;
            d_r <= '0;
        end else if (load) begin
            q_r <= dividend_in;
            r_r <= '0;
            d_r <= divisor_in;
        end else if (step) begin
            r_r <= fits ? diff[XLEN-1:0] : trial[XLEN-1:0];
            q_r <= {q_r[DW-2:0], fits};
        end
    end

    assign quot = q_r;
    assign rem  = r_r;

endmodule

// File: rtl/emd_unit.sv
module emd_unit
    import emd_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     op_div,
    input  logic [1:0]               size,
    input  logic [$clog2(NREG)-1:0]  dst_idx,
    input  logic [XLEN-1:0]          dst_val,
    input  logic [XLEN-1:0]          dst_next_val,
    input  logic [XLEN-1:0]          src_val,
    output logic                     busy,
    output logic                     done,
    output logic                     err_align,
    output logic                     err_zero,
    output logic                     wr0_en,
    output logic [$clog2(NREG)-1:0]  wr0_idx,
    output logic [XLEN-1:0]          wr0_data,
    output logic                     wr1_en,
    output logic [$clog2(NREG)-1:0]  wr1_idx,
    output logic [XLEN-1:0]          wr1_data
);
    localparam int RW = $clog2(NREG);
    localparam int DW = 2 * XLEN;
    localparam int WW = XLEN / 2;
    localparam int CW = $clog2(DW + 1);

    emd_state_e state_q, state_d;
    emd_size_e  sz_in;
    emd_size_e  c_size;
    logic [RW-1:0]   c_dst;
    logic [XLEN-1:0] c_a, c_b;
    logic            c_zero;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   steps_m1;

    logic            align_bad, zero_bad;
    logic [XLEN-1:0] divisor;
    logic [DW-1:0]   dividend;
    logic [DW-1:0]   prod;
    logic [DW-1:0]   quot;
    logic [XLEN-1:0] rem;
    logic            accept;

    assign sz_in  = emd_size_e'(size);
    assign accept = (state_q == ST_IDLE) && start;

    emd_opcheck #(.XLEN(XLEN)) u_check (
        .op_div    (op_div),
        .size      (size),
        .dst_lo    (dst_idx[1:0]),
        .src_val   (src_val),
        .align_bad (align_bad),
        .zero_bad  (zero_bad),
        .divisor   (divisor)
    );

    emd_mul #(.XLEN(XLEN)) u_mul (
        .size (c_size),
        .a    (c_a),
        .b    (c_b),
        .prod (prod)
    );

    // dividend left-aligned so its top bit is shifted out first
    always_comb begin
        unique case (sz_in)
            SZ_HALF: begin
                dividend = {dst_val[WW-1:0], {(DW-WW){1'b0}}};
                steps_m1 = CW'(WW - 1);
            end
            SZ_WORD: begin
                dividend = {dst_val, {XLEN{1'b0}}};
                steps_m1 = CW'(XLEN - 1);
            end
            default: begin
                dividend = {dst_val, dst_next_val};
                steps_m1 = CW'(DW - 1);
            end
        endcase
    end

    emd_div #(.XLEN(XLEN)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept && op_div),
        .step        (state_q == ST_DIV_RUN),
        .dividend_in (dividend),
        .divisor_in  (divisor),
        .quot        (quot),
        .rem         (rem)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (align_bad || zero_bad) begin
                        state_d = ST_FAULT;
                    end else if (op_div) begin
                        state_d = ST_DIV_RUN;
                    end else begin
                        state_d = ST_MUL_WB;
                    end
                end
            end
            ST_DIV_RUN: begin
                if (cnt_q == '0) begin
                    state_d = ST_DIV_WB_A;
                end
            end
            ST_DIV_WB_A: begin
                state_d = (c_size == SZ_LONG) ? ST_DIV_WB_B : ST_IDLE;
            end
            ST_MUL_WB, ST_DIV_WB_B, ST_FAULT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // request capture and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_size <= SZ_HALF;
            c_dst  <= '0;
            c_a    <= '0;
            c_b    <= '0;
            c_zero <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            c_size <= sz_in;
            c_dst  <= dst_idx;
            c_a    <= dst_val;
            c_b    <= src_val;
            c_zero <= zero_bad;
            cnt_q  <= steps_m1;
        end else if ((state_q == ST_DIV_RUN) && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = 1'b0;
        err_align = 1'b0;
        err_zero  = 1'b0;
        wr0_en    = 1'b0;
        wr0_idx   = '0;
        wr0_data  = '0;
        wr1_en    = 1'b0;
        wr1_idx   = '0;
        wr1_data  = '0;
        unique case (state_q)
            ST_IDLE, ST_DIV_RUN: begin
            end
            ST_MUL_WB: begin
                done = 1'b1;
                if (c_size == SZ_LONG) begin
                    wr0_en   = 1'b1;
                    wr0_idx  = c_dst - RW'(1);
                    wr0_data = prod[DW-1:XLEN];
                    wr1_en   = 1'b1;
                    wr1_idx  = c_dst;
                    wr1_data = prod[XLEN-1:0];
                end else begin
                    wr0_en   = 1'b1;
                    wr0_idx  = c_dst;
                    wr0_data = prod[XLEN-1:0];
                end
            end
            ST_DIV_WB_A: begin
                wr0_en  = 1'b1;
                wr0_idx = c_dst;
                wr1_en  = 1'b1;
                wr1_idx = c_dst + RW'(1);
                if (c_size == SZ_LONG) begin
                    wr0_data = '0;
                    wr1_data = rem;
                end else begin
                    done     = 1'b1;
                    wr0_data = rem;
                    wr1_data = quot[XLEN-1:0];
                end
            end
            ST_DIV_WB_B: begin
                done     = 1'b1;
                wr0_en   = 1'b1;
                wr0_idx  = c_dst + RW'(2);
                wr0_data = quot[DW-1:XLEN];
                wr1_en   = 1'b1;
                wr1_idx  = c_dst + RW'(3);
                wr1_data = quot[XLEN-1:0];
            end
            ST_FAULT: begin
                done      = 1'b1;
                err_zero  = c_zero;
                err_align = !c_zero;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/emd_chk.sv
module emd_chk #(
    parameter int XLEN = 64,
    parameter int NREG = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic                    err_align,
    input logic                    err_zero,
    input logic                    wr0_en,
    input logic [$clog2(NREG)-1:0] wr0_idx,
    input logic [XLEN-1:0]         wr0_data,
    input logic                    wr1_en,
    input logic [$clog2(NREG)-1:0] wr1_idx,
    input logic [XLEN-1:0]         wr1_data
);
    localparam int RW = $clog2(NREG);

    logic unused_data;
    assign unused_data = ^{wr0_data, wr1_data};

    // R11
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R11
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R9
    fault_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_align || err_zero) |-> (done && !wr0_en && !wr1_en));

    // R10
    one_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_align, err_zero}));

    // R1
    write_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en || wr1_en) |-> busy);

    // R4
    lane_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en && wr1_en) |-> (wr1_idx == RW'(wr0_idx + 1'b1)));

endmodule

bind emd_unit emd_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err_align (err_align),
    .err_zero  (err_zero),
    .wr0_en    (wr0_en),
    .wr0_idx   (wr0_idx),
    .wr0_data  (wr0_data),
    .wr1_en    (wr1_en),
    .wr1_idx   (wr1_idx),
    .wr1_data  (wr1_data)
);

// File: tb/tb_emd_unit.sv
module tb_emd_unit;
    localparam int XLEN = 64;
    localparam int NREG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic [1:0]  size = 2'b00;
    logic [2:0]  dst_idx = 3'd0;
    logic [63:0] dst_val = '0, dst_next_val = '0, src_val = '0;
    logic        busy, done, err_align, err_zero, wr0_en, wr1_en;
    logic [2:0]  wr0_idx, wr1_idx;
    logic [63:0] wr0_data, wr1_data;

    int checks = 0;
    int fails = 0;
    bit over = 1'b0;

    always #10 clk = ~clk;

    emd_unit #(.XLEN(XLEN), .NREG(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div), .size(size),
        .dst_idx(dst_idx), .dst_val(dst_val), .dst_next_val(dst_next_val),
        .src_val(src_val), .busy(busy), .done(done), .err_align(err_align),
        .err_zero(err_zero), .wr0_en(wr0_en), .wr0_idx(wr0_idx),
        .wr0_data(wr0_data), .wr1_en(wr1_en), .wr1_idx(wr1_idx),
        .wr1_data(wr1_data)
    );

    task automatic check_cycle(input string tag, input logic eb, input logic ed,
                               input logic eea, input logic eez,
                               input logic e0, input logic [2:0] i0, input logic [63:0] d0,
                               input logic e1, input logic [2:0] i1, input logic [63:0] d1);
        bit ok;
        checks++;
        ok = (busy === eb) && (done === ed) && (err_align === eea) && (err_zero === eez)
             && (wr0_en === e0) && (wr1_en === e1)
             && (!e0 || (wr0_idx === i0 && wr0_data === d0))
             && (!e1 || (wr1_idx === i1 && wr1_data === d1));
        if (!ok) begin
            fails++;
            $display("FAIL %s: got b=%0b d=%0b ea=%0b ez=%0b w0=%0b/%0d/%h w1=%0b/%0d/%h expected b=%0b d=%0b ea=%0b ez=%0b w0=%0b/%0d/%h w1=%0b/%0d/%h",
                     tag, busy, done, err_align, err_zero, wr0_en, wr0_idx, wr0_data,
                     wr1_en, wr1_idx, wr1_data, eb, ed, eea, eez, e0, i0, d0, e1, i1, d1);
        end
    endtask

    task automatic next_cycle(input bit junk, input bit div, input logic [2:0] d);
        @(negedge clk);
        if (junk) begin
            start        = 1'b1;
            op_div       = ~div;
            size         = 2'b01;
            dst_idx      = ~d;
            dst_val      = 64'hA5A5_5A5A_0F0F_F0F0;
            dst_next_val = 64'h1111_2222_3333_4444;
            src_val      = 64'h0;
        end else begin
            start = 1'b0;
        end
    endtask

    task automatic run_op(input string tag, input bit div, input logic [1:0] sz,
                          input logic [2:0] d, input logic [63:0] dv, input logic [63:0] nv,
                          input logic [63:0] sv, input bit junk);
        bit ea, ez;
        int n;
        logic [127:0] am, bm, prod, dd, dsr, q, r;
        ea = (sz == 2'b11) || (!div && sz == 2'b10 && !d[0])
             || (div && sz == 2'b10 && d[1:0] != 2'b00)
             || (div && sz != 2'b10 && d[0]);
        dsr = (sz == 2'b00) ? {112'b0, sv[15:0]} :
              (sz == 2'b01) ? {96'b0, sv[31:0]} : {64'b0, sv};
        ez = div && !ea && (dsr == 0);

        @(negedge clk);
        start = 1'b1; op_div = div; size = sz; dst_idx = d;
        dst_val = dv; dst_next_val = nv; src_val = sv;

        if (ea || ez) begin
            next_cycle(0, div, d);
            check_cycle(tag, 1, 1, ea, ez, 0, 0, 0, 0, 0, 0);
        end else if (!div) begin
            am = (sz == 2'b00) ? {112'b0, dv[15:0]} :
                 (sz == 2'b01) ? {96'b0, dv[31:0]} : {64'b0, dv};
            bm = (sz == 2'b00) ? {112'b0, sv[15:0]} :
                 (sz == 2'b01) ? {96'b0, sv[31:0]} : {64'b0, sv};
            prod = am * bm;
            next_cycle(0, div, d);
            if (sz == 2'b10)
                check_cycle(tag, 1, 1, 0, 0, 1, 3'(d - 1), prod[127:64], 1, d, prod[63:0]);
            else
                check_cycle(tag, 1, 1, 0, 0, 1, d, prod[63:0], 0, 0, 0);
        end else begin
            dd = (sz == 2'b00) ? {96'b0, dv[31:0]} :
                 (sz == 2'b01) ? {64'b0, dv} : {dv, nv};
            q = dd / dsr;
            r = dd % dsr;
            n = (sz == 2'b00) ? 32 : (sz == 2'b01) ? 64 : 128;
            for (int i = 0; i < n; i++) begin
                next_cycle(junk, div, d);
                check_cycle(tag, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            end
            if (sz != 2'b10) begin
                next_cycle(0, div, d);
                check_cycle(tag, 1, 1, 0, 0, 1, d, r[63:0], 1, 3'(d + 1), q[63:0]);
            end else begin
                next_cycle(junk, div, d);
                check_cycle(tag, 1, 0, 0, 0, 1, d, r[127:64], 1, 3'(d + 1), r[63:0]);
                next_cycle(0, div, d);
                check_cycle(tag, 1, 1, 0, 0, 1, 3'(d + 2), q[127:64], 1, 3'(d + 3), q[63:0]);
            end
        end
        next_cycle(0, div, d);
        check_cycle({tag, " R11 idle after done"}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!over) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected run to end");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_cycle("R1 in reset", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_cycle("R1 after reset", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R3 multiply halfword and integer, upper bits must not matter
        run_op("R3 mul half", 0, 2'b00, 3'd2, 64'hFFFF_FFFF_FFFF_1234, 0, 64'h7777_0000_0000_ABCD, 0);
        run_op("R3 mul word", 0, 2'b01, 3'd5, 64'h1234_5678_FFFF_FFFF, 0, 64'h9999_0000_FFFF_FFFF, 0);
        // R4 multiply long into odd pairs
        run_op("R4 mul long", 0, 2'b10, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        run_op("R4 mul long top", 0, 2'b10, 3'd7, 64'h0123_4567_89AB_CDEF, 0, 64'hFEDC_BA98_7654_3210, 0);
        // R5 halfword divide, with start junk during run (R2)
        run_op("R5 R2 div half", 1, 2'b00, 3'd2, 64'hDEAD_BEEF_0012_3457, 0, 64'hFFFF_0000_0000_0007, 1);
        run_op("R8 div half max", 1, 2'b00, 3'd0, 64'h0000_0000_FFFF_FFFF, 0, 64'h1, 0);
        // R6 integer divide
        run_op("R6 R2 div word", 1, 2'b01, 3'd6, 64'h0123_4567_89AB_CDEF, 0, 64'hABCD_0000_0000_1234, 1);
        run_op("R8 div word max", 1, 2'b01, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'h1, 0);
        // R7 long divide
        run_op("R7 R2 div long", 1, 2'b10, 3'd4, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0000_0001_0000_0003, 1);
        run_op("R7 div long big rem", 1, 2'b10, 3'd0, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        run_op("R8 div long max", 1, 2'b10, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0);
        // R9 alignment rules
        run_op("R9 mul long even", 0, 2'b10, 3'd4, 64'h5, 0, 64'h6, 0);
        run_op("R9 div half odd", 1, 2'b00, 3'd3, 64'h5, 0, 64'h6, 0);
        run_op("R9 div word odd", 1, 2'b01, 3'd7, 64'h5, 0, 64'h6, 0);
        run_op("R9 div long not x4", 1, 2'b10, 3'd2, 64'h5, 0, 64'h6, 0);
        run_op("R9 reserved size", 0, 2'b11, 3'd1, 64'h5, 0, 64'h6, 0);
        // R10 zero divisor
        run_op("R10 div half zero", 1, 2'b00, 3'd2, 64'h1234, 0, 64'hFFFF_FFFF_FFFF_0000, 0);
        run_op("R10 div long zero", 1, 2'b10, 3'd0, 64'h1, 64'h2, 64'h0, 0);
        run_op("R10 align wins", 1, 2'b01, 3'd1, 64'h1, 0, 64'h0, 0);
        // R3 after faults: unit still works
        run_op("R3 mul after fault", 0, 2'b00, 3'd7, 64'h0, 0, 64'hFFFF, 0);

        over = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule